// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter

This block arbitrates one shared bus among eight masters. Each master drives a request line and receives a one-hot grant line. Every master has an effective priority level from 0 to 7, and level 0 is the most urgent. A small register interface holds two registers. The first packs one 4-bit field per master and holds the software-programmed levels. The second holds one select bit per master. That bit chooses between the programmed level and a fixed, built-in level for that master.

Grants are registered. When no master owns the bus, the arbiter grants the requesting master with the best effective level, and the lowest-numbered master wins a tie. The owner keeps the grant for as long as it keeps requesting. The arbiter chooses again in the cycle after the owner drops its request. A register write changes arbitration one clock after the cycle in which it is written.

Top module: `prio_arbiter`

## Requirements
- R1: After reset, address 0 reads 0x11111110 and address 1 reads 0x00000000. No grant is asserted during reset or in the first cycle after it.
- R2: The level of master m is stored in bits [4m+2:4m] of address 0. A numerically smaller level has higher priority.
- R3: Bit 4m+3 of address 0 is reserved for every master m. It always reads 0, and writing 1 to it has no effect. Bits 31:8 of address 1 read 0. Addresses 2 and 3 read 0 and ignore writes.
- R4: Bit m of address 1 selects the source of master m's effective level. A value of 1 selects the programmed field and a value of 0 selects the built-in level. The built-in levels are 7 for master 0, 2 for master 1, 1 for master 2 and 7 for masters 3 to 7.
- R5: When the bus is free and at least one request is present, the next cycle grants the requester with the smallest effective level. On a tie, the lowest-numbered requester wins.
- R6: A write is captured on a clock edge. The grant decided on that same edge still uses the old register contents. Grants decided on later edges use the new contents.
- R7: Once master m holds the grant, the grant stays with m in every following cycle in which m's request was asserted on the previous edge, whatever the other masters request.
- R8: The cycle after the owner drops its request, the grant moves to the R5 winner among the masters still requesting, or to no master if none is requesting.
- R9: At most one grant bit is high in any cycle. No grant is high in the cycle after a cycle with no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 8 | Request line for each master |
| gnt | output | 8 | Registered one-hot grant for each master |
| reg_addr | input | 2 | Register address (0 = levels, 1 = source select) |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, available in the same cycle |

## Verification
A corrupted level field or select bit does not stay hidden. It shows up on reg_rdata at once, and it grants the wrong master one cycle after the next free-bus request pattern that involves that master. A fault in the ownership state shows up on the very next edge: a grant moves away from a master that is still requesting, the bus stays with a master that has let go, or two grant bits go high together. The bench sweeps all 256 request patterns from an idle bus under several level and select settings. This exposes ordering and tie-break faults within a single cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // Built-in level used when a master's select bit is clear.
    function automatic int hw_level(input int m);
        case (m)
            1:       return 2;
            2:       return 1;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/arb_regs.sv
module arb_regs #(
    parameter int NUM_M  = 8,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      we,
    input  logic [NUM_M*(LVL_W+1)-1:0] wdata,
    output logic [NUM_M*(LVL_W+1)-1:0] rdata,
    output logic [NUM_M*(LVL_W+1)-1:0] prio_o,
    output logic [NUM_M-1:0]          sel_o
);
    localparam int FLD_W = LVL_W + 1;
    localparam int DW    = NUM_M * FLD_W;

    function automatic logic [DW-1:0] mk_rsv();
        logic [DW-1:0] v = '0;
        for (int m = 0; m < NUM_M; m++) v[m*FLD_W+LVL_W] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] mk_init();
        logic [DW-1:0] v = '0;
        for (int m = 1; m < NUM_M; m++) v[m*FLD_W] = 1'b1;
        return v;
    endfunction

    localparam logic [DW-1:0] RSV_MASK = mk_rsv();
    localparam logic [DW-1:0] INIT_VAL = mk_init();

    typedef struct packed {
        logic [DW-1:0]    prio;
        logic [NUM_M-1:0] sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && addr == ADDR_W'(0)) st_d.prio = wdata & ~RSV_MASK;
        if (we && addr == ADDR_W'(1)) st_d.sel  = wdata[NUM_M-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prio <= INIT_VAL;
            st_q.sel  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(0): rdata = st_q.prio;
            ADDR_W'(1): rdata = {{(DW-NUM_M){1'b0}}, st_q.sel};
            default:    rdata = '0;
        endcase
    end

    assign prio_o = st_q.prio;
    assign sel_o  = st_q.sel;

    // R3
    always_comb begin
        if (rst_n) begin
            rsv_zero_chk: assert ((prio_o & RSV_MASK) == '0);
        end
    end
endmodule

// File: rtl/arb_level_sel.sv
module arb_level_sel #(
    parameter int NUM_M = 8,
    parameter int LVL_W = 3
) (
    input  logic [NUM_M*(LVL_W+1)-1:0] prio,
    input  logic [NUM_M-1:0]           sel,
    output logic [NUM_M*LVL_W-1:0]     lvl
);
    localparam int FLD_W = LVL_W + 1;

    for (genvar m = 0; m < NUM_M; m++) begin : g_lvl
        localparam logic [LVL_W-1:0] HW = LVL_W'(arb_pkg::hw_level(m));
        assign lvl[m*LVL_W +: LVL_W] = sel[m] ? prio[m*FLD_W +: LVL_W] : HW;
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_M = 8,
    parameter int LVL_W = 3
) (
    input  logic [NUM_M-1:0]       req,
    input  logic [NUM_M*LVL_W-1:0] lvl,
    output logic [NUM_M-1:0]       win
);
    localparam int IDX_W = $clog2(NUM_M);

    logic [LVL_W-1:0] best;
    logic [IDX_W-1:0] idx;
    logic             found;

    // Scan from the top so a tie leaves the lowest index in place.
    always_comb begin
        best  = '1;
        idx   = '0;
        found = 1'b0;
        for (int m = NUM_M - 1; m >= 0; m--) begin
            if (req[m] && (!found || lvl[m*LVL_W +: LVL_W] <= best)) begin
                best  = lvl[m*LVL_W +: LVL_W];
                idx   = IDX_W'(m);
                found = 1'b1;
            end
        end
        win = found ? (NUM_M'(1) << idx) : '0;
    end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
    parameter int NUM_M  = 8,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_M-1:0]          req,
    output logic [NUM_M-1:0]          gnt,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_we,
    input  logic [NUM_M*(LVL_W+1)-1:0] reg_wdata,
    output logic [NUM_M*(LVL_W+1)-1:0] reg_rdata
);
    localparam int DW = NUM_M * (LVL_W + 1);

    logic [DW-1:0]          prio;
    logic [NUM_M-1:0]       sel;
    logic [NUM_M*LVL_W-1:0] lvl;
    logic [NUM_M-1:0]       win;

    arb_regs #(.NUM_M(NUM_M), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .prio_o(prio), .sel_o(sel)
    );

    arb_level_sel #(.NUM_M(NUM_M), .LVL_W(LVL_W)) u_lvl (
        .prio(prio), .sel(sel), .lvl(lvl)
    );

    arb_pick #(.NUM_M(NUM_M), .LVL_W(LVL_W)) u_pick (
        .req(req), .lvl(lvl), .win(win)
    );

    typedef struct packed {
        logic [NUM_M-1:0] gnt;
    } own_t;

    own_t own_d, own_q;
    logic hold;

    always_comb begin
        hold      = |(own_q.gnt & req);
        own_d.gnt = hold ? own_q.gnt : win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own_d;
    end

    assign gnt = own_q.gnt;

    // R9
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9
    no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (gnt == '0));

    // R7
    hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gnt & req)) |=> (gnt == $past(gnt)));

    // R5
    gnt_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> ((gnt & ~$past(req)) == '0));
endmodule

// File: tb/sim_prio_arbiter.sv
module sim_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic [7:0]  gnt;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_prio;
    logic [7:0]  m_sel;

    always #5 clk = ~clk;

    prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int eff_lvl(input int m, input logic [31:0] p, input logic [7:0] s);
        if (s[m]) return int'(p[m*4 +: 3]);
        if (m == 1) return 2;
        if (m == 2) return 1;
        return 7;
    endfunction

    function automatic logic [7:0] exp_win(input logic [7:0] r, input logic [31:0] p, input logic [7:0] s);
        int best = 8;
        int who = -1;
        for (int m = 0; m < 8; m++) begin
            if (r[m] && eff_lvl(m, p, s) < best) begin
                best = eff_lvl(m, p, s);
                who = m;
            end
        end
        return (who < 0) ? 8'h00 : (8'h01 << who);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Bring the bus idle, then present r and check the grant.
    task automatic arb(input string tag, input logic [7:0] r);
        @(negedge clk); req = '0;
        @(posedge clk); #1;
        chk("R9 idle", {24'b0, gnt}, 32'h0);
        @(negedge clk); req = r;
        @(posedge clk); #1;
        chk(tag, {24'b0, gnt}, {24'b0, exp_win(r, m_prio, m_sel)});
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < 256; r++) arb(tag, 8'(r));
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1; chk("R1 gnt in reset", {24'b0, gnt}, 32'h0);
        #30; rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 gnt after reset", {24'b0, gnt}, 32'h0);
        rd("R1 levels reset", 2'd0, 32'h11111110);
        rd("R1 select reset", 2'd1, 32'h0);
        m_prio = 32'h11111110; m_sel = 8'h00;

        // R4 built-in levels
        sweep("R4 builtin");
        // R4 programmed reset levels, R5 ties
        wr(2'd1, 32'hFFFF_FFFF);
        m_sel = 8'hFF;
        rd("R3 select upper bits", 2'd1, 32'h0000_00FF);
        sweep("R5 reset levels");

        // R3 reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        m_prio = 32'h77777777;
        rd("R3 reserved read", 2'd0, 32'h77777777);
        arb("R3 all level7 tie", 8'hF0);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        rd("R3 addr2 reads 0", 2'd2, 32'h0);
        rd("R3 levels untouched", 2'd0, 32'h77777777);

        // R2 field layout
        wr(2'd0, 32'h35062714);
        m_prio = 32'h35062714;
        rd("R2 readback", 2'd0, 32'h35062714);
        sweep("R2 programmed");
        wr(2'd1, 32'h0000_005A);
        m_sel = 8'h5A;
        sweep("R4 mixed select");
        wr(2'd1, 32'h0000_00FF);
        m_sel = 8'hFF;

        // R6 write timing: old levels m0=4 m7=3 -> m7; new m0=0 m7=5
        @(negedge clk); req = '0;
        @(posedge clk); #1;
        @(negedge clk);
        req = 8'h81; reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 32'h55555550;
        @(posedge clk); #1;
        reg_we = 1'b0;
        chk("R6 old value on write edge", {24'b0, gnt}, 32'h80);
        m_prio = 32'h55555550;
        arb("R6 new value next", 8'h81);
        chk("R6 new winner m0", {24'b0, gnt}, 32'h01);

        // R7 hold, R8 re-arbitration
        arb("R7 start m3", 8'h08);
        @(negedge clk); req = 8'hFF;
        @(posedge clk); #1;
        chk("R7 hold vs all", {24'b0, gnt}, 32'h08);
        @(posedge clk); #1;
        chk("R7 hold second", {24'b0, gnt}, 32'h08);
        @(negedge clk); req = 8'hF7;
        @(posedge clk); #1;
        chk("R8 handover", {24'b0, gnt}, {24'b0, exp_win(8'hF7, m_prio, m_sel)});
        @(negedge clk); req = 8'h00;
        @(posedge clk); #1;
        chk("R8 release to none", {24'b0, gnt}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule